// File: doc/BRIEF.md
# Framed-Message SPI Master

This block is an SPI master that runs a whole chip-select framed message for each command written by software. Software fills a transmit byte buffer through a small register port. It sets a message length and a message kind, and then writes a command word. The command word carries a start opcode, a count of write-only lead-in ("prepend") bytes and a target device number. The controller pulls the selected chip-select line low and clocks out the prepend bytes and then the typed message phase. It captures MISO into a separate receive buffer, releases chip select and flags completion through a status bit and an interrupt line.

The message phase can be full duplex, half-duplex read or half-duplex write. Prepend bytes are always sent and never captured, so a command byte followed by a read is one frame. The received bytes land at receive-buffer offset 0. Serial clock rate, clock polarity and clock phase are set in a configuration register. The serial clock runs at the reference clock divided by a power of two.

Top module: `msg_spi_master`

## Requirements
- R1: After reset the status register reads 0, every chip-select line is high (inactive), irq is 0 and mosi is 0.
- R2: A write to command offset 3 starts a command only when bits [3:0] equal 1. Bits [7:4] give the prepend count and bits [10:8] give the device number. Any other opcode starts nothing.
- R3: In full-duplex kind (kind register offset 2 value 0), each message byte is taken from the transmit buffer and sent MSB first. The byte received at the same time is stored in the receive buffer, starting at offset 0.
- R4: In half-duplex write kind (value 2, and value 3 treated the same), the transmit bytes are sent and the receive buffer is left unchanged.
- R5: In half-duplex read kind (value 1), mosi stays 0 during the message bytes and the received bytes are stored from receive offset 0.
- R6: A prepend count P (0..15) sends transmit-buffer bytes 0..P-1 first, with no capture. The message phase then uses transmit offsets P onward, and receive storage still starts at offset 0.
- R7: Only the chip-select line selected by the device number goes low. It stays low, without a break, across all bytes of the command and goes high when the command ends.
- R8: Configuration bits [2:0] select a serial-clock half period of 2^sel reference cycles. Value 7 acts as 6.
- R9: Configuration bit 3 (CPOL) sets the idle sclk level. Bit 4 (CPHA) selects sampling on the leading edge (0) or the trailing edge (1), with data launched on the other edge.
- R10: Status bit 0 is set when a command ends and is cleared by writing 1 to it; writing 0 leaves it set. irq equals status bit 0 AND mask register (offset 5) bit 0.
- R11: Status bit 1 reads 1 from an accepted start until the end of the command. A start written while it is 1 is ignored.
- R12: A start whose total (prepend plus length) is 0 or exceeds the buffer depth is ignored. No chip select is asserted and no done is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register/buffer write strobe |
| addr | input | AW | Address: [AW-1:AW-2] = 0 registers, 1 transmit buffer, 2 receive buffer |
| wdata | input | 11 | Write data |
| rdata | output | 11 | Read data for addr (combinational) |
| irq | output | 1 | Done interrupt, masked |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
A table of commands covers every message kind, all four clock modes, several clock rates including the aliased top value, and every prepend situation: none, one byte, and the 15-byte maximum that fills the buffer exactly. A bench slave model shifts a known pattern and records mosi. Checking the captured bytes against the receive buffer shows whether data is captured on the right edge, skipped during prepend, or left untouched in write-only kinds. Directed cases cover commands that must be ignored: a wrong opcode, a zero or oversized total, and a start while busy. They also cover write-one-to-clear with mask gating of the interrupt.

// File: rtl/msp_pkg.sv
package msp_pkg;

    localparam int BUS_W    = 11;
    localparam int MAX_RATE = 6;
    localparam int DIV_W    = MAX_RATE;

    localparam logic [3:0] START_OP = 4'h1;

    localparam logic [2:0] REG_CFG  = 3'd0;
    localparam logic [2:0] REG_LEN  = 3'd1;
    localparam logic [2:0] REG_KIND = 3'd2;
    localparam logic [2:0] REG_CMD  = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;
    localparam logic [2:0] REG_MASK = 3'd5;

    localparam logic [1:0] WIN_REG = 2'd0;
    localparam logic [1:0] WIN_TX  = 2'd1;
    localparam logic [1:0] WIN_RX  = 2'd2;

    typedef enum logic [1:0] {
        KIND_FDX  = 2'd0,
        KIND_HRD  = 2'd1,
        KIND_HWR  = 2'd2,
        KIND_HWR3 = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic       cpha;
        logic       cpol;
        logic [2:0] rate;
    } spi_cfg_t;

    function automatic logic [2:0] eff_rate(input logic [2:0] sel);
        return (sel > 3'(MAX_RATE)) ? 3'(MAX_RATE) : sel;
    endfunction

    function automatic logic kind_stores(input msg_kind_e k);
        return (k == KIND_FDX) || (k == KIND_HRD);
    endfunction

endpackage

// File: rtl/msp_bytebuf.sv
module msp_bytebuf #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/msp_clkdiv.sv
module msp_clkdiv
    import msp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    assign last = DIV_W'((7'd1 << eff_rate(sel)) - 7'd1);
    assign tick = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt <= '0;
        else if (cnt == last)       cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    // R8: above the fastest rate, ticks never come on consecutive cycles
    a_r8_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && eff_rate(sel) != 3'd0) |=> !tick);
endmodule

// File: rtl/msp_shift.sv
module msp_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       cpha,
    input  logic       tick,
    input  logic       miso,
    output logic       active,
    output logic       ph,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done
);
    logic [7:0] sh;
    logic [3:0] ecnt;
    logic       lead;

    assign lead = ~ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            ph      <= 1'b0;
            ecnt    <= '0;
            sh      <= '0;
            rx_byte <= '0;
            mosi    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                active <= 1'b1;
                ph     <= 1'b0;
                ecnt   <= '0;
                if (!cpha) begin
                    mosi <= tx_byte[7];
                    sh   <= {tx_byte[6:0], 1'b0};
                end else begin
                    sh   <= tx_byte;
                end
            end else if (active && tick) begin
                ph   <= ~ph;
                ecnt <= ecnt + 1'b1;
                if (lead ^ cpha) begin
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    mosi <= sh[7];
                    sh   <= {sh[6:0], 1'b0};
                end
                if (ecnt == 4'd15) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // R9: the clock phase is back at its idle level whenever no byte is in flight
    a_r9_phase_home: assert property (@(posedge clk) disable iff (rst)
        (!active && !load) |-> (ph == 1'b0));
    // R3: a byte completes only out of an active shift
    a_r3_done_from_active: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(active));
endmodule

// File: rtl/msg_spi_master.sv
module msg_spi_master
    import msp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NCS   = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int TOT_W = LEN_W + 1,
    localparam int AW    = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic [NCS-1:0]   cs_n
);
    // register window decode
    logic [1:0]       win;
    logic [2:0]       off3;
    logic [IDX_W-1:0] boff;
    logic             reg_we, cmd_wr, start_req, start_ok;

    assign win    = addr[AW-1:AW-2];
    assign off3   = addr[2:0];
    assign boff   = addr[IDX_W-1:0];
    assign reg_we = wr_en && (win == WIN_REG);
    assign cmd_wr = reg_we && (off3 == REG_CMD);
    assign start_req = cmd_wr && (wdata[3:0] == START_OP);

    spi_cfg_t     cfg_q, cfg_l;
    logic [LEN_W-1:0] len_q;
    msg_kind_e    kind_q;
    logic         mask_q, done_q;

    seq_state_e   st;
    logic [3:0]   cur_p;
    logic [2:0]   cur_dev;
    msg_kind_e    cur_kind;
    logic [TOT_W-1:0] cur_total, idx, rxp, tot_w;

    logic [3:0]   cmd_prep;
    logic [2:0]   cmd_dev;
    logic         busy, cs_act, in_msg, hrd_phase, store;

    assign cmd_prep = wdata[7:4];
    assign cmd_dev  = wdata[10:8];
    assign tot_w    = TOT_W'(len_q) + TOT_W'(cmd_prep);
    assign start_ok = start_req && (st == ST_IDLE) && (tot_w != '0)
                      && (tot_w <= TOT_W'(DEPTH));

    assign busy      = (st != ST_IDLE);
    assign cs_act    = (st == ST_LOAD) || (st == ST_WAIT);
    assign in_msg    = (idx >= TOT_W'(cur_p));
    assign hrd_phase = in_msg && (cur_kind == KIND_HRD);
    assign store     = in_msg && kind_stores(cur_kind);

    // shifter and clock engine
    logic       sh_active, sh_ph, sh_mosi, sh_done, tick;
    logic [7:0] sh_rx, tx_rd, rx_rd, sh_tx;

    assign sh_tx = hrd_phase ? 8'h00 : tx_rd;

    msp_clkdiv u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (sh_active),
        .restart (st == ST_LOAD),
        .sel     (cfg_l.rate),
        .tick    (tick)
    );

    msp_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (st == ST_LOAD),
        .tx_byte (sh_tx),
        .cpha    (cfg_l.cpha),
        .tick    (tick),
        .miso    (miso),
        .active  (sh_active),
        .ph      (sh_ph),
        .mosi    (sh_mosi),
        .rx_byte (sh_rx),
        .done    (sh_done)
    );

    msp_bytebuf #(.DEPTH(DEPTH)) u_txbuf (
        .clk   (clk),
        .we    (wr_en && (win == WIN_TX)),
        .waddr (boff),
        .wdata (wdata[7:0]),
        .raddr (idx[IDX_W-1:0]),
        .rdata (tx_rd)
    );

    logic rx_we;
    assign rx_we = (st == ST_WAIT) && sh_done && store;

    msp_bytebuf #(.DEPTH(DEPTH)) u_rxbuf (
        .clk   (clk),
        .we    (rx_we),
        .waddr (rxp[IDX_W-1:0]),
        .wdata (sh_rx),
        .raddr (boff),
        .rdata (rx_rd)
    );

    // software-visible registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            len_q  <= '0;
            kind_q <= KIND_FDX;
            mask_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (reg_we) begin
                case (off3)
                    REG_CFG:  cfg_q  <= spi_cfg_t'(wdata[4:0]);
                    REG_LEN:  len_q  <= wdata[LEN_W-1:0];
                    REG_KIND: kind_q <= msg_kind_e'(wdata[1:0]);
                    REG_MASK: mask_q <= wdata[0];
                    default: ;
                endcase
            end
            if (st == ST_FIN)
                done_q <= 1'b1;
            else if (reg_we && (off3 == REG_STAT) && wdata[0])
                done_q <= 1'b0;
        end
    end

    // command sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cfg_l     <= '0;
            cur_p     <= '0;
            cur_dev   <= '0;
            cur_kind  <= KIND_FDX;
            cur_total <= '0;
            idx       <= '0;
            rxp       <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    cfg_l <= cfg_q;
                    if (start_ok) begin
                        st        <= ST_LOAD;
                        cur_p     <= cmd_prep;
                        cur_dev   <= cmd_dev;
                        cur_kind  <= kind_q;
                        cur_total <= tot_w;
                        idx       <= '0;
                        rxp       <= '0;
                    end
                end
                ST_LOAD: st <= ST_WAIT;
                ST_WAIT: begin
                    if (sh_done) begin
                        idx <= idx + 1'b1;
                        if (store) rxp <= rxp + 1'b1;
                        st <= (idx + 1'b1 == cur_total) ? ST_FIN : ST_LOAD;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // pins
    assign sclk = cfg_l.cpol ^ sh_ph;
    assign mosi = cs_act && !hrd_phase && sh_mosi;
    assign irq  = done_q && mask_q;

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = ~(cs_act && (cur_dev == 3'(g)));
    end

    always_comb begin
        rdata = '0;
        case (win)
            WIN_REG: begin
                case (off3)
                    REG_CFG:  rdata = BUS_W'(cfg_q);
                    REG_LEN:  rdata = BUS_W'(len_q);
                    REG_KIND: rdata = BUS_W'(kind_q);
                    REG_STAT: rdata = BUS_W'({busy, done_q});
                    REG_MASK: rdata = BUS_W'(mask_q);
                    default:  rdata = '0;
                endcase
            end
            WIN_RX:  rdata = BUS_W'(rx_rd);
            default: rdata = '0;
        endcase
    end

    // R7: at most one chip select is low at a time
    a_r7_cs_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    // R7: no chip select is low while the sequencer is idle
    a_r7_cs_idle_high: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> (&cs_n));
    // R11: a start written while busy leaves the selected device untouched
    a_r11_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start_req) |=> $stable(cur_dev));
    // R10: the done flag rises only out of the closing state
    a_r10_done_after_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(st == ST_FIN));
    // R12: a start with an illegal total does not leave idle
    a_r12_reject_total: assert property (@(posedge clk) disable iff (rst)
        (start_req && (st == ST_IDLE) && !start_ok) |=> (st == ST_IDLE));
endmodule

// File: tb/msg_spi_master_bench.sv
`timescale 1ns/1ps
module msg_spi_master_bench;
    localparam int DEPTH = 64;
    localparam int NCS   = 8;
    localparam int AW    = 8;
    localparam int NV    = 8;

    // {dev[20:18], len[17:11], prep[10:7], kind[6:5], cpha[4], cpol[3], rate[2:0]}
    localparam logic [20:0] VEC [NV] = '{
        {3'd0, 7'd4,  4'd0,  2'd0, 1'b0, 1'b0, 3'd0},
        {3'd3, 7'd3,  4'd0,  2'd2, 1'b1, 1'b0, 3'd1},
        {3'd5, 7'd5,  4'd2,  2'd1, 1'b0, 1'b1, 3'd2},
        {3'd7, 7'd2,  4'd3,  2'd0, 1'b1, 1'b1, 3'd0},
        {3'd1, 7'd1,  4'd0,  2'd1, 1'b0, 1'b0, 3'd7},
        {3'd2, 7'd49, 4'd15, 2'd0, 1'b0, 1'b0, 3'd0},
        {3'd4, 7'd2,  4'd1,  2'd3, 1'b1, 1'b0, 3'd3},
        {3'd6, 7'd64, 4'd0,  2'd1, 1'b1, 1'b1, 3'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [10:0] wdata = '0;
    logic [10:0] rdata;
    logic irq, sclk, mosi;
    logic miso = 1'b0;
    logic [NCS-1:0] cs_n;

    always #10 clk = ~clk;

    msg_spi_master u_msg_spi_master (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_n(cs_n)
    );

    int n_checks = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // slave model
    int cur_seed = 0;
    logic cur_cpol = 1'b0, cur_cpha = 1'b0;
    int nbits = 0, outp = 0, nedges = 0, cs_falls = 0;
    realtime t0 = 0, t1 = 0;
    logic [7:0] cap [128];
    logic [NCS-1:0] seen = '0;
    wire cs_all = &cs_n;

    function automatic logic [7:0] spat(input int k);
        return 8'(k * 29 + cur_seed * 17 + 90);
    endfunction

    function automatic logic sbit(input int k);
        logic [7:0] b;
        b = spat(k / 8);
        return b[7 - (k % 8)];
    endfunction

    always @(negedge cs_all) begin
        cs_falls++;
        nbits = 0;
        nedges = 0;
        if (!cur_cpha) begin
            miso = sbit(0);
            outp = 1;
        end else begin
            outp = 0;
        end
    end

    always @(cs_n) seen = seen | ~cs_n;

    always @(sclk) begin
        if (!cs_all) begin
            nedges++;
            if (nedges == 1) t0 = $realtime;
            if (nedges == 2) t1 = $realtime;
            if ((sclk != cur_cpol) != cur_cpha) begin
                cap[nbits / 8][7 - (nbits % 8)] = mosi;
                nbits++;
            end else begin
                miso = sbit(outp);
                outp++;
            end
        end
    end

    task automatic bus_wr(input logic [AW-1:0] a, input logic [10:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [10:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [10:0] s;
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(8'h04, s);
            if (s[0]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic arm_monitor();
        seen = '0;
        cs_falls = 0;
        nedges = 0;
    endtask

    logic [7:0] rx_exp [DEPTH];
    bit         rx_known [DEPTH];

    initial begin
        #(200000 * 20);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        logic [10:0] d;
        bit ok;
        for (int j = 0; j < DEPTH; j++) rx_known[j] = 1'b0;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        bus_rd(8'h04, d);
        check(d == 0, "R1", "status after reset", int'(d), 0);
        check(cs_n == '1, "R1", "cs_n after reset", int'(cs_n), 255);
        check(irq == 1'b0 && mosi == 1'b0, "R1", "irq/mosi after reset",
              int'({irq, mosi}), 0);
        check(sclk == 1'b0, "R1", "sclk after reset", int'(sclk), 0);

        // table of commands
        for (int v = 0; v < NV; v++) begin
            logic [2:0] rate, dev;
            logic cpol, cpha;
            logic [1:0] kind;
            int p, len, tot, half;
            logic [7:0] txd [DEPTH];
            bit good;
            rate = VEC[v][2:0]; cpol = VEC[v][3]; cpha = VEC[v][4];
            kind = VEC[v][6:5]; p = int'(VEC[v][10:7]);
            len = int'(VEC[v][17:11]); dev = VEC[v][20:18];
            tot = p + len;
            cur_seed = v; cur_cpol = cpol; cur_cpha = cpha;

            bus_wr(8'h00, {6'b0, cpha, cpol, rate});
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(sclk == cpol, "R9", "idle sclk level", int'(sclk), int'(cpol));

            for (int i = 0; i < tot; i++) begin
                txd[i] = 8'(i * 37 + v * 11 + 3);
                bus_wr(8'h40 + AW'(i), {3'b0, txd[i]});
            end
            bus_wr(8'h01, 11'(len));
            bus_wr(8'h02, {9'b0, kind});
            arm_monitor();
            bus_wr(8'h03, {dev, 4'(p), 4'h1});
            wait_done(ok);
            check(ok, "R2", "command completes", int'(ok), 1);

            // mosi stream: prepend then message (zeros in half-duplex read)
            good = 1'b1;
            for (int i = 0; i < tot; i++) begin
                logic [7:0] e;
                e = (i >= p && kind == 2'd1) ? 8'h00 : txd[i];
                if (cap[i] !== e) good = 1'b0;
            end
            check(good, (kind == 2'd1) ? "R5" : (p > 0 ? "R6" : "R3"),
                  "mosi bytes", v, 1);
            check(nbits == tot * 8, "R7", "bits in one frame", nbits, tot * 8);
            check(cs_falls == 1, "R7", "single cs assertion", cs_falls, 1);
            check(seen == NCS'(1 << dev), "R7", "selected line", int'(seen),
                  1 << dev);
            half = 20 * (1 << ((rate == 3'd7) ? 6 : int'(rate)));
            check(int'(t1 - t0) == half, "R8", "sclk half period",
                  int'(t1 - t0), half);

            // receive buffer model
            if (kind == 2'd0 || kind == 2'd1) begin
                for (int j = 0; j < len; j++) begin
                    rx_exp[j] = spat(p + j);
                    rx_known[j] = 1'b1;
                end
            end
            good = 1'b1;
            for (int j = 0; j < DEPTH; j++) begin
                if (rx_known[j]) begin
                    bus_rd(8'h80 + AW'(j), d);
                    if (d[7:0] !== rx_exp[j]) good = 1'b0;
                end
            end
            check(good, (kind >= 2'd2) ? "R4" : ((kind == 2'd1) ? "R5" : "R3"),
                  "receive buffer", v, 1);
            check(cs_n == '1, "R7", "cs released", int'(cs_n), 255);

            bus_wr(8'h04, 11'h001);
            bus_rd(8'h04, d);
            check(d == 0, "R10", "done cleared", int'(d), 0);
        end

        cur_seed = 9; cur_cpol = 1'b0; cur_cpha = 1'b0;
        bus_wr(8'h00, 11'h000);
        bus_wr(8'h02, 11'h000);

        // R2: wrong opcode does nothing
        bus_wr(8'h01, 11'd2);
        arm_monitor();
        bus_wr(8'h03, {3'd1, 4'd0, 4'h2});
        repeat (40) @(posedge clk);
        bus_rd(8'h04, d);
        check(d == 0 && cs_falls == 0, "R2", "non-start opcode", int'(d), 0);

        // R12: zero total and oversized total
        bus_wr(8'h01, 11'd0);
        bus_wr(8'h03, {3'd1, 4'd0, 4'h1});
        repeat (40) @(posedge clk);
        bus_rd(8'h04, d);
        check(d == 0 && cs_falls == 0, "R12", "zero total ignored", int'(d), 0);
        bus_wr(8'h01, 11'd64);
        bus_wr(8'h03, {3'd1, 4'd1, 4'h1});
        repeat (40) @(posedge clk);
        bus_rd(8'h04, d);
        check(d == 0 && cs_falls == 0, "R12", "total 65 ignored", int'(d), 0);

        // R11: busy flag and start while busy
        bus_wr(8'h00, 11'h007);
        repeat (3) @(posedge clk);
        bus_wr(8'h01, 11'd2);
        arm_monitor();
        bus_wr(8'h03, {3'd1, 4'd0, 4'h1});
        repeat (20) @(posedge clk);
        bus_rd(8'h04, d);
        check(d[1] == 1'b1, "R11", "busy while running", int'(d[1]), 1);
        bus_wr(8'h03, {3'd6, 4'd0, 4'h1});
        wait_done(ok);
        bus_rd(8'h04, d);
        check(ok && d[1] == 1'b0, "R11", "busy clear at end", int'(d[1]), 0);
        check(seen == 8'h02 && cs_falls == 1, "R11", "second start ignored",
              int'(seen), 2);

        // R10: mask gating and write-one-to-clear
        @(negedge clk);
        check(irq == 1'b0, "R10", "irq masked", int'(irq), 0);
        bus_wr(8'h05, 11'h001);
        @(negedge clk);
        check(irq == 1'b1, "R10", "irq unmasked", int'(irq), 1);
        bus_wr(8'h04, 11'h000);
        bus_rd(8'h04, d);
        check(d[0] == 1'b1, "R10", "write 0 keeps done", int'(d[0]), 1);
        bus_wr(8'h04, 11'h001);
        @(negedge clk);
        check(irq == 1'b0, "R10", "irq after clear", int'(irq), 0);

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule